// File: doc/BRIEF.md
# Indirect Branch Landing-Pad Checker

This block watches the retirement stream of a simple in-order hart with user (U), supervisor (S) and machine (M) modes. It keeps a single "landing pad owed" flag. The flag is armed when an indirect jump retires in a mode whose enable bit is set. It is discharged when the designated landing-pad word retires. If any other instruction tries to retire while the flag is armed, the block suppresses that retirement and requests an illegal-instruction trap.

The flag lives across traps. When the core takes a trap, the flag is copied into a saved bit that belongs to the target mode (S or M), and the live flag is cleared. The matching return (SRET or MRET) reloads the flag from that saved bit and then clears the saved bit. As a result, a fault at a jump target, or a return to a target that is not a landing pad, still ends in a trap. The block also holds the three per-mode enable bits and applies the privilege rules that decide who may write each one.

Top module: `lpad_guard`

## Requirements
- R1: After reset, the flag, both saved bits, all three enables and the trap request are 0.
- R2: An indirect jump that retires with `ret_is_ijump`=1 arms the flag only if the enable for `cur_mode` is set. Mode encoding: U=0, S=1, M=3; the value 2 has no enable.
- R3: While the flag is armed, a retiring word other than the landing pad raises `trap_req` in the same cycle with `trap_cause`=2 (illegal instruction). The flag stays armed.
- R4: Retirement of the landing-pad word (parameter `PAD_WORD`, default 32'h0050_0013, compared over all 32 bits) clears the flag. When the flag is already clear, the landing pad has no effect.
- R5: `trap_taken` with `trap_to_mode`=1 copies the flag into `sprev`. With `trap_to_mode`=3 it copies the flag into `mprev`. In both cases the live flag is then cleared.
- R6: `sret` reloads the flag from `sprev` and clears `sprev`. `mret` reloads the flag from `mprev` and clears `mprev`.
- R7: `en_wr` with `en_wr_mode`=0 writes the U enable, and only from S or M mode. `en_wr_mode`=1 writes the S enable, and only from M mode. `en_wr_mode`=3 can only set the M enable, and only from M mode. Once set, the M enable stays set until reset.
- R8: `pv_wr` with `pv_wr_m`=0 writes `sprev`, and only from S or M mode. `pv_wr_m`=1 writes `mprev`, and only from M mode.
- R9: A 16-bit instruction word (low two bits not 2'b11) never matches the landing pad, so it traps while the flag is armed.
- R10: An indirect jump that retires while the flag is armed traps, just as any other non-pad word does, and leaves the flag armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_mode | input | 2 | Current privilege mode |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_instr | input | 32 | Retiring instruction word |
| ret_is_ijump | input | 1 | Retiring instruction is an indirect jump |
| trap_taken | input | 1 | The core takes a trap this cycle |
| trap_to_mode | input | 2 | Mode that receives the trap |
| sret | input | 1 | Supervisor return |
| mret | input | 1 | Machine return |
| en_wr | input | 1 | Enable-bit write strobe |
| en_wr_mode | input | 2 | Mode whose enable is written |
| en_wr_val | input | 1 | Enable write data |
| pv_wr | input | 1 | Saved-bit write strobe |
| pv_wr_m | input | 1 | 0 selects sprev, 1 selects mprev |
| pv_wr_val | input | 1 | Saved-bit write data |
| trap_req | output | 1 | Suppress the retirement and trap |
| trap_cause | output | 4 | Cause code, 2 when trap_req is high |
| track | output | 1 | Live landing-pad flag |
| sprev | output | 1 | Flag saved on a trap into S |
| mprev | output | 1 | Flag saved on a trap into M |
| en_u | output | 1 | U-mode enable |
| en_s | output | 1 | S-mode enable |
| en_m | output | 1 | M-mode enable |

## Verification
The bench first tries every enable write from a mode that is too low. A design with loose privilege checks would let U code switch off its own tracking, or let M clear its sticky enable. The bench then sends a violation, takes a trap into each mode and returns. A design that cleared the flag on the trap instead of saving it, or that forgot to clear the saved bit on return, would let a faulted or returned-to target run without a landing pad. Finally, the bench retires a compressed word, and then an indirect jump, while the flag is armed. A design that matched only part of the word, or that re-armed on the jump instead of trapping, would miss the trap.

// File: rtl/lpad_pkg.sv
package lpad_pkg;

    typedef enum logic [1:0] {
        MODE_U   = 2'd0,
        MODE_S   = 2'd1,
        MODE_RSV = 2'd2,
        MODE_M   = 2'd3
    } mode_e;

    typedef struct packed {
        logic en_u;
        logic en_s;
        logic en_m;
    } enables_t;

    typedef struct packed {
        logic track;
        logic sprev;
        logic mprev;
    } trk_t;

endpackage

// File: rtl/lpad_enables.sv
module lpad_enables
    import lpad_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cur_mode,
    input  logic       wr,
    input  logic [1:0] wr_mode,
    input  logic       wr_val,
    output logic       en_u,
    output logic       en_s,
    output logic       en_m
);

    enables_t en_d, en_q;
    logic     from_s_or_m;
    logic     from_m;

    always_comb begin
        from_m      = (cur_mode == MODE_M);
        from_s_or_m = from_m || (cur_mode == MODE_S);
        en_d        = en_q;
        if (wr) begin
            case (wr_mode)
                MODE_U:  if (from_s_or_m) en_d.en_u = wr_val;
                MODE_S:  if (from_m) en_d.en_s = wr_val;
                MODE_M:  if (from_m && wr_val) en_d.en_m = 1'b1;
                default: en_d = en_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en_u = en_q.en_u;
    assign en_s = en_q.en_s;
    assign en_m = en_q.en_m;

    // R7: code running in U mode can change no enable
    a_r7_user_cannot_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_U) |=> $stable(en_q));

    // R7: the S enable moves only under M mode
    a_r7_s_needs_machine: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != MODE_M) |=> $stable(en_q.en_s));

    // R7: the M enable is sticky once set
    a_r7_m_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        en_q.en_m |=> en_q.en_m);

endmodule

// File: rtl/lpad_tracker.sv
module lpad_tracker
    import lpad_pkg::*;
#(
    parameter int              ILEN     = 32,
    parameter logic [ILEN-1:0] PAD_WORD = 32'h0050_0013
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cur_mode,
    input  logic            ret_valid,
    input  logic [ILEN-1:0] ret_instr,
    input  logic            ret_is_ijump,
    input  logic            en_u,
    input  logic            en_s,
    input  logic            en_m,
    input  logic            trap_taken,
    input  logic [1:0]      trap_to_mode,
    input  logic            sret,
    input  logic            mret,
    input  logic            pv_wr,
    input  logic            pv_wr_m,
    input  logic            pv_wr_val,
    output logic            viol,
    output logic            track,
    output logic            sprev,
    output logic            mprev
);

    trk_t trk_d, trk_q;
    logic is_pad;
    logic cur_en;

    always_comb begin
        is_pad = (ret_instr == PAD_WORD);
        case (cur_mode)
            MODE_U:  cur_en = en_u;
            MODE_S:  cur_en = en_s;
            MODE_M:  cur_en = en_m;
            default: cur_en = 1'b0;
        endcase
        viol  = ret_valid && !trap_taken && trk_q.track && !is_pad;
        trk_d = trk_q;
        if (trap_taken) begin
            if (trap_to_mode == MODE_M)      trk_d.mprev = trk_q.track;
            else if (trap_to_mode == MODE_S) trk_d.sprev = trk_q.track;
            trk_d.track = 1'b0;
        end else if (mret) begin
            trk_d.track = trk_q.mprev;
            trk_d.mprev = 1'b0;
        end else if (sret) begin
            trk_d.track = trk_q.sprev;
            trk_d.sprev = 1'b0;
        end else begin
            if (pv_wr) begin
                if (pv_wr_m) begin
                    if (cur_mode == MODE_M) trk_d.mprev = pv_wr_val;
                end else if (cur_mode == MODE_M || cur_mode == MODE_S) begin
                    trk_d.sprev = pv_wr_val;
                end
            end
            if (ret_valid && !viol) begin
                if (is_pad)                      trk_d.track = 1'b0;
                else if (ret_is_ijump && cur_en) trk_d.track = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign track = trk_q.track;
    assign sprev = trk_q.sprev;
    assign mprev = trk_q.mprev;

    // R2: a jump in a disabled mode leaves a clear flag clear
    a_r2_disabled_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_is_ijump && !cur_en && !trk_q.track && !trap_taken && !sret && !mret)
        |=> !trk_q.track);

    // R3: a suppressed retirement keeps the flag armed
    a_r3_hold_on_violation: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && !sret && !mret) |=> trk_q.track);

    // R4: the landing pad discharges the flag
    a_r4_pad_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && is_pad && !trap_taken && !sret && !mret) |=> !trk_q.track);

    // R5: a trap into M saves the flag and clears it
    a_r5_save_machine: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && trap_to_mode == MODE_M)
        |=> (trk_q.mprev == $past(trk_q.track)) && !trk_q.track);

    // R6: MRET consumes the saved M bit
    a_r6_mret_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mret && !trap_taken) |=> !trk_q.mprev);

endmodule

// File: rtl/lpad_guard.sv
module lpad_guard
    import lpad_pkg::*;
#(
    parameter int               ILEN      = 32,
    parameter logic [ILEN-1:0]  PAD_WORD  = 32'h0050_0013,
    parameter int               CAUSE_W   = 4,
    parameter logic [CAUSE_W-1:0] CAUSE_ILL = 4'd2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cur_mode,
    input  logic            ret_valid,
    input  logic [ILEN-1:0] ret_instr,
    input  logic            ret_is_ijump,
    input  logic            trap_taken,
    input  logic [1:0]      trap_to_mode,
    input  logic            sret,
    input  logic            mret,
    input  logic            en_wr,
    input  logic [1:0]      en_wr_mode,
    input  logic            en_wr_val,
    input  logic            pv_wr,
    input  logic            pv_wr_m,
    input  logic            pv_wr_val,
    output logic            trap_req,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic            track,
    output logic            sprev,
    output logic            mprev,
    output logic            en_u,
    output logic            en_s,
    output logic            en_m
);

    logic viol;

    lpad_enables i_enables (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur_mode(cur_mode),
        .wr      (en_wr),
        .wr_mode (en_wr_mode),
        .wr_val  (en_wr_val),
        .en_u    (en_u),
        .en_s    (en_s),
        .en_m    (en_m)
    );

    lpad_tracker #(
        .ILEN    (ILEN),
        .PAD_WORD(PAD_WORD)
    ) i_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_mode    (cur_mode),
        .ret_valid   (ret_valid),
        .ret_instr   (ret_instr),
        .ret_is_ijump(ret_is_ijump),
        .en_u        (en_u),
        .en_s        (en_s),
        .en_m        (en_m),
        .trap_taken  (trap_taken),
        .trap_to_mode(trap_to_mode),
        .sret        (sret),
        .mret        (mret),
        .pv_wr       (pv_wr),
        .pv_wr_m     (pv_wr_m),
        .pv_wr_val   (pv_wr_val),
        .viol        (viol),
        .track       (track),
        .sprev       (sprev),
        .mprev       (mprev)
    );

    assign trap_req   = viol;
    assign trap_cause = viol ? CAUSE_ILL : '0;

    // R3: the cause code accompanies every trap request
    a_r3_cause_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_cause == CAUSE_ILL));

endmodule

// File: tb/test_lpad_guard.sv
module test_lpad_guard;

    localparam logic [31:0] PAD  = 32'h0050_0013;
    localparam logic [31:0] NOP  = 32'h0000_0013;
    localparam logic [31:0] JALR = 32'h0000_8067;
    localparam logic [31:0] C16  = 32'h0000_4505;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cur_mode;
    logic        ret_valid;
    logic [31:0] ret_instr;
    logic        ret_is_ijump;
    logic        trap_taken;
    logic [1:0]  trap_to_mode;
    logic        sret, mret;
    logic        en_wr;
    logic [1:0]  en_wr_mode;
    logic        en_wr_val;
    logic        pv_wr, pv_wr_m, pv_wr_val;
    logic        trap_req;
    logic [3:0]  trap_cause;
    logic        track, sprev, mprev, en_u, en_s, en_m;

    int   n_checks = 0;
    int   n_fail   = 0;
    logic seen_req;
    logic [3:0] seen_cause;

    always #10 clk = ~clk;

    lpad_guard i_lpad_guard (
        .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode),
        .ret_valid(ret_valid), .ret_instr(ret_instr), .ret_is_ijump(ret_is_ijump),
        .trap_taken(trap_taken), .trap_to_mode(trap_to_mode),
        .sret(sret), .mret(mret),
        .en_wr(en_wr), .en_wr_mode(en_wr_mode), .en_wr_val(en_wr_val),
        .pv_wr(pv_wr), .pv_wr_m(pv_wr_m), .pv_wr_val(pv_wr_val),
        .trap_req(trap_req), .trap_cause(trap_cause),
        .track(track), .sprev(sprev), .mprev(mprev),
        .en_u(en_u), .en_s(en_s), .en_m(en_m)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        ret_valid = 0; ret_instr = '0; ret_is_ijump = 0;
        trap_taken = 0; trap_to_mode = 2'd0; sret = 0; mret = 0;
        en_wr = 0; en_wr_mode = 2'd0; en_wr_val = 0;
        pv_wr = 0; pv_wr_m = 0; pv_wr_val = 0;
    endtask

    // inputs are driven just after a falling edge; combinational outputs
    // are sampled mid-phase, registered ones after the next falling edge
    task automatic tick();
        #5;
        seen_req   = trap_req;
        seen_cause = trap_cause;
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic retire(input logic [31:0] w, input logic ij);
        ret_valid = 1; ret_instr = w; ret_is_ijump = ij;
        tick();
    endtask

    task automatic wr_en(input logic [1:0] m, input logic v);
        en_wr = 1; en_wr_mode = m; en_wr_val = v;
        tick();
    endtask

    task automatic wr_pv(input logic m, input logic v);
        pv_wr = 1; pv_wr_m = m; pv_wr_val = v;
        tick();
    endtask

    task automatic take_trap(input logic [1:0] m);
        trap_taken = 1; trap_to_mode = m;
        tick();
    endtask

    task automatic do_sret(); sret = 1; tick(); endtask
    task automatic do_mret(); mret = 1; tick(); endtask

    task automatic t_reset();
        chk("R1 track", track, 0);
        chk("R1 sprev", sprev, 0);
        chk("R1 mprev", mprev, 0);
        chk("R1 en_u", en_u, 0);
        chk("R1 en_s", en_s, 0);
        chk("R1 en_m", en_m, 0);
        chk("R1 trap_req", trap_req, 0);
    endtask

    task automatic t_enables();
        cur_mode = 2'd0;
        wr_en(2'd0, 1); chk("R7 U writes U enable", en_u, 0);
        wr_en(2'd1, 1); chk("R7 U writes S enable", en_s, 0);
        cur_mode = 2'd1;
        wr_en(2'd1, 1); chk("R7 S writes S enable", en_s, 0);
        wr_en(2'd0, 1); chk("R7 S writes U enable", en_u, 1);
        wr_en(2'd3, 1); chk("R7 S writes M enable", en_m, 0);
        cur_mode = 2'd3;
        wr_en(2'd1, 1); chk("R7 M writes S enable", en_s, 1);
        wr_en(2'd3, 1); chk("R7 M sets M enable", en_m, 1);
        wr_en(2'd3, 0); chk("R7 M enable sticky", en_m, 1);
    endtask

    task automatic t_jump();
        cur_mode = 2'd0;
        retire(JALR, 1); chk("R2 jump arms flag", track, 1);
        retire(PAD, 0);
        chk("R4 pad no trap", seen_req, 0);
        chk("R4 pad clears flag", track, 0);
        retire(PAD, 0);
        chk("R4 idle pad no trap", seen_req, 0);
        chk("R4 idle pad no effect", track, 0);
        cur_mode = 2'd1; wr_en(2'd0, 0);
        cur_mode = 2'd0;
        retire(JALR, 1); chk("R2 disabled mode no arm", track, 0);
        cur_mode = 2'd1; wr_en(2'd0, 1);
    endtask

    task automatic t_violation();
        cur_mode = 2'd1;
        retire(JALR, 1); chk("R2 S jump arms", track, 1);
        retire(NOP, 0);
        chk("R3 trap_req", seen_req, 1);
        chk("R3 cause", seen_cause, 2);
        chk("R3 flag held", track, 1);
        take_trap(2'd3);
        chk("R5 mprev saved", mprev, 1);
        chk("R5 flag cleared", track, 0);
        do_mret();
        chk("R6 mret reload", track, 1);
        chk("R6 mret clears mprev", mprev, 0);
        retire(PAD, 0); chk("R4 pad after return", track, 0);
    endtask

    task automatic t_sret();
        cur_mode = 2'd0;
        retire(JALR, 1); chk("R2 U jump arms", track, 1);
        take_trap(2'd1);
        chk("R5 sprev saved", sprev, 1);
        chk("R5 mprev untouched", mprev, 0);
        chk("R5 flag cleared S", track, 0);
        do_sret();
        chk("R6 sret reload", track, 1);
        chk("R6 sret clears sprev", sprev, 0);
        retire(JALR, 1);
        chk("R10 jump on armed traps", seen_req, 1);
        chk("R10 flag still armed", track, 1);
        retire(PAD, 0); chk("R4 pad clears", track, 0);
    endtask

    task automatic t_compressed();
        cur_mode = 2'd3;
        retire(JALR, 1); chk("R2 M jump arms", track, 1);
        retire(C16, 0);
        chk("R9 16-bit word traps", seen_req, 1);
        chk("R9 flag kept", track, 1);
        retire(PAD, 0); chk("R9 pad clears", track, 0);
    endtask

    task automatic t_prev();
        cur_mode = 2'd1;
        wr_pv(1'b0, 1); chk("R8 S writes sprev", sprev, 1);
        wr_pv(1'b1, 1); chk("R8 S writes mprev", mprev, 0);
        cur_mode = 2'd0;
        wr_pv(1'b0, 0); chk("R8 U writes sprev", sprev, 1);
        cur_mode = 2'd3;
        wr_pv(1'b1, 1); chk("R8 M writes mprev", mprev, 1);
        do_mret(); chk("R6 mret from written bit", track, 1);
        retire(PAD, 0);
        do_sret(); chk("R6 sret from written bit", track, 1);
        chk("R6 sprev consumed", sprev, 0);
        retire(PAD, 0); chk("R4 final clear", track, 0);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        clear_inputs();
        cur_mode = 2'd0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_enables();
        t_jump();
        t_violation();
        t_sret();
        t_compressed();
        t_prev();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule